// File: doc/BRIEF.md
# UART Event Collector with Interrupt Masking

This block gathers the event conditions of one UART channel and its buffer handling logic into a 16-bit sticky event register. A second 16-bit register holds one enable bit per event. The block raises a single interrupt request whenever an enabled event is pending. Software reads both registers through a small register port and acknowledges events by writing ones to the event register.

The receive side supplies single-cycle strobes for the following conditions:
- a break character or a normal character,
- the end of a break,
- a control character stored,
- a character dropped for lack of buffer space,
- a buffer closed at mid stop bit,
- glitches, idle, address match and graceful stop.

The transmit side supplies two strobes and a per-buffer flag:
- a strobe when the last character enters the FIFO,
- a strobe when the last stop bit first goes out on the line,
- a flag that chooses which of the two strobes completes the buffer.

When a dropped character is reported while multidrop operation is selected, the block asks the receiver to return to hunt mode. Only the first break of a break run is reported as a break start.

Top module: `uart_evt_irq`

## Requirements
- R1: After reset both registers read 0, `irq` is 0 and `hunt_req` is 0.
- R2: Event bit positions, counted from the LSB as bit 0, are as follows. Each bit is set one clock after its strobe.
  - Bit 0: buffer closed at mid stop bit.
  - Bit 1: transmit done.
  - Bit 2: receive drop.
  - Bit 3: control character stored.
  - Bit 5: break start.
  - Bit 6: break end.
  - Bit 7: graceful stop.
  - Bit 8: idle.
  - Bit 9: address match.
  - Bit 11: transmit glitch.
  - Bit 12: receive glitch.
- R3: Event bits are sticky. Writing 1 to an event bit at address 0 clears that bit, and writing 0 leaves it unchanged.
- R4: When an event sets a bit in the same cycle that a write clears that bit, the bit ends set.
- R5: Bits 4, 10, 13, 14 and 15 of both registers always read 0 and ignore writes.
- R6: A break character sets bit 5 only when the break latch is armed, and every break character disarms the latch. A normal character re-arms the latch. If both strobes arrive in the same cycle, the break takes priority.
- R7: When `tx_cts_wait` is 1, bit 1 is set by `tx_last_stop`. When `tx_cts_wait` is 0, bit 1 is set by `tx_last_fifo`. In either case the other strobe has no effect.
- R8: `rx_drop` with `multidrop` at 1 makes `hunt_req` 1 for the next cycle. With `multidrop` at 0, `hunt_req` stays 0.
- R9: Address 1 holds the mask register, and a write there loads it. `irq` is 1 exactly when (event AND mask) is non-zero. `irq` follows the registers in the same cycle that they change.
- R10: `reg_rdata` shows the event register when `reg_addr` is 0 and the mask register when `reg_addr` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the event register, 1 selects the mask register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| rx_glitch | input | 1 | Glitch seen on the receive line |
| tx_glitch | input | 1 | Glitch seen on the transmit clock |
| addr_hit | input | 1 | Address character matched |
| idle_seen | input | 1 | Line became idle |
| stop_done | input | 1 | Graceful stop completed |
| brk_end | input | 1 | Break ended |
| brk_char | input | 1 | Break character received |
| norm_char | input | 1 | Normal (non-break) character received |
| ctl_stored | input | 1 | Control character stored |
| rx_drop | input | 1 | Character discarded because no buffer was free |
| rx_close | input | 1 | Receive buffer closed at mid stop bit |
| tx_last_fifo | input | 1 | Last character of the buffer written to the FIFO |
| tx_last_stop | input | 1 | Last stop bit of the buffer first transmitted |
| tx_cts_wait | input | 1 | Per-buffer flag selecting which strobe completes the buffer |
| multidrop | input | 1 | Multidrop operation selected |
| irq | output | 1 | Interrupt request |
| hunt_req | output | 1 | One-cycle request for the receiver to enter hunt mode |

## Verification
Two functions can act on the same event bit in the same cycle: a new event setting the bit and a write-one clear from software. The bench provokes this directly by driving the strobe and the clearing write on one edge, and the random phase repeats it by mixing strobes with random clear writes. After each such edge the event register is read back and compared with a model in which the set wins, and `irq` is compared as well. The break latch faces a similar collision when a break and a normal character arrive together; the expected result there is a disarmed latch.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
    localparam int REG_W = 16;

    // Event bit indices, counted from the LSB
    localparam int B_RXCLOSE = 0;
    localparam int B_TXDONE  = 1;
    localparam int B_DROP    = 2;
    localparam int B_CTL     = 3;
    localparam int B_BRKBEG  = 5;
    localparam int B_BRKEND  = 6;
    localparam int B_STOP    = 7;
    localparam int B_IDLE    = 8;
    localparam int B_ADDR    = 9;
    localparam int B_TXGL    = 11;
    localparam int B_RXGL    = 12;

    localparam logic [REG_W-1:0] VALID_BITS = 16'h1BEF;

    typedef struct packed {
        logic armed;
        logic hunt;
    } cap_state_t;

    typedef struct packed {
        logic [REG_W-1:0] evt;
        logic [REG_W-1:0] mask;
    } reg_state_t;
endpackage

// File: rtl/uart_evt_capture.sv
module uart_evt_capture
    import uart_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_glitch,
    input  logic             tx_glitch,
    input  logic             addr_hit,
    input  logic             idle_seen,
    input  logic             stop_done,
    input  logic             brk_end,
    input  logic             brk_char,
    input  logic             norm_char,
    input  logic             ctl_stored,
    input  logic             rx_drop,
    input  logic             rx_close,
    input  logic             tx_last_fifo,
    input  logic             tx_last_stop,
    input  logic             tx_cts_wait,
    input  logic             multidrop,
    output logic [REG_W-1:0] set_o,
    output logic             hunt_o
);
    cap_state_t st_d, st_q;
    logic brk_fire;
    logic tx_fire;

    always_comb begin
        st_d     = st_q;
        brk_fire = brk_char && st_q.armed;
        tx_fire  = tx_cts_wait ? tx_last_stop : tx_last_fifo;
        if (brk_char)       st_d.armed = 1'b0;
        else if (norm_char) st_d.armed = 1'b1;
        st_d.hunt = rx_drop && multidrop;

        set_o            = '0;
        set_o[B_RXCLOSE] = rx_close;
        set_o[B_TXDONE]  = tx_fire;
        set_o[B_DROP]    = rx_drop;
        set_o[B_CTL]     = ctl_stored;
        set_o[B_BRKBEG]  = brk_fire;
        set_o[B_BRKEND]  = brk_end;
        set_o[B_STOP]    = stop_done;
        set_o[B_IDLE]    = idle_seen;
        set_o[B_ADDR]    = addr_hit;
        set_o[B_TXGL]    = tx_glitch;
        set_o[B_RXGL]    = rx_glitch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.armed <= 1'b1;
            st_q.hunt  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hunt_o = st_q.hunt;

    // R6
    brk_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_o[B_BRKBEG] && !norm_char) |=> !set_o[B_BRKBEG]);

    // R8
    hunt_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_drop && multidrop) |=> hunt_o);

    // R8
    hunt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !multidrop |=> !hunt_o);
endmodule

// File: rtl/uart_evt_regs.sv
module uart_evt_regs
    import uart_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_i,
    input  logic             wr_i,
    input  logic             addr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    output logic             irq_o
);
    reg_state_t st_d, st_q;
    logic [REG_W-1:0] clr;

    always_comb begin
        st_d = st_q;
        clr  = (wr_i && !addr_i) ? wdata_i : '0;
        for (int i = 0; i < REG_W; i++) begin
            if (VALID_BITS[i]) st_d.evt[i] = set_i[i] | (st_q.evt[i] & ~clr[i]);
            else               st_d.evt[i] = 1'b0;
        end
        if (wr_i && addr_i) st_d.mask = wdata_i & VALID_BITS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = addr_i ? st_q.mask : st_q.evt;
    assign irq_o   = |(st_q.evt & st_q.mask);

    // R5
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.evt | st_q.mask) & ~VALID_BITS) == '0);

    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && !addr_i) |=> ((st_q.evt & $past(st_q.evt)) == $past(st_q.evt)));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & VALID_BITS) != '0) |=>
            ((st_q.evt & $past(set_i & VALID_BITS)) == $past(set_i & VALID_BITS)));

    // R9
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i && wdata_i == '0) |=> !irq_o);
endmodule

// File: rtl/uart_evt_irq.sv
module uart_evt_irq
    import uart_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        rx_glitch,
    input  logic        tx_glitch,
    input  logic        addr_hit,
    input  logic        idle_seen,
    input  logic        stop_done,
    input  logic        brk_end,
    input  logic        brk_char,
    input  logic        norm_char,
    input  logic        ctl_stored,
    input  logic        rx_drop,
    input  logic        rx_close,
    input  logic        tx_last_fifo,
    input  logic        tx_last_stop,
    input  logic        tx_cts_wait,
    input  logic        multidrop,
    output logic        irq,
    output logic        hunt_req
);
    logic [REG_W-1:0] set_vec;

    uart_evt_capture u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_glitch    (rx_glitch),
        .tx_glitch    (tx_glitch),
        .addr_hit     (addr_hit),
        .idle_seen    (idle_seen),
        .stop_done    (stop_done),
        .brk_end      (brk_end),
        .brk_char     (brk_char),
        .norm_char    (norm_char),
        .ctl_stored   (ctl_stored),
        .rx_drop      (rx_drop),
        .rx_close     (rx_close),
        .tx_last_fifo (tx_last_fifo),
        .tx_last_stop (tx_last_stop),
        .tx_cts_wait  (tx_cts_wait),
        .multidrop    (multidrop),
        .set_o        (set_vec),
        .hunt_o       (hunt_req)
    );

    uart_evt_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .irq_o   (irq)
    );
endmodule

// File: tb/uart_evt_irq_bench.sv
`timescale 1ns/1ps
module uart_evt_irq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic rx_glitch = 0, tx_glitch = 0, addr_hit = 0, idle_seen = 0, stop_done = 0;
    logic brk_end = 0, brk_char = 0, norm_char = 0, ctl_stored = 0, rx_drop = 0;
    logic rx_close = 0, tx_last_fifo = 0, tx_last_stop = 0, tx_cts_wait = 0, multidrop = 0;
    logic irq, hunt_req;

    int n_chk = 0, n_bad = 0;
    logic [15:0] m_evt = '0, m_mask = '0;
    logic m_armed = 1'b1, m_hunt = 1'b0;
    localparam logic [15:0] OK_BITS = 16'h1BEF;

    always #2.5 clk = ~clk;

    uart_evt_irq u_uart_evt_irq (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] set_of();
        logic [15:0] s = '0;
        s[0]  = rx_close;
        s[1]  = tx_cts_wait ? tx_last_stop : tx_last_fifo;
        s[2]  = rx_drop;
        s[3]  = ctl_stored;
        s[5]  = brk_char & m_armed;
        s[6]  = brk_end;
        s[7]  = stop_done;
        s[8]  = idle_seen;
        s[9]  = addr_hit;
        s[11] = tx_glitch;
        s[12] = rx_glitch;
        return s;
    endfunction

    task automatic quiet();
        {rx_glitch, tx_glitch, addr_hit, idle_seen, stop_done, brk_end, brk_char,
         norm_char, ctl_stored, rx_drop, rx_close, tx_last_fifo, tx_last_stop} = '0;
        reg_wr = 1'b0;
    endtask

    // inputs already driven after a negedge; clock once, update model, check
    task automatic tick(input string req);
        logic [15:0] clr;
        logic [15:0] s;
        @(posedge clk);
        s   = set_of();
        clr = (reg_wr && !reg_addr) ? reg_wdata : '0;
        m_evt = ((m_evt & ~clr) | s) & OK_BITS;
        if (reg_wr && reg_addr) m_mask = reg_wdata & OK_BITS;
        if (brk_char) m_armed = 1'b0; else if (norm_char) m_armed = 1'b1;
        m_hunt = rx_drop & multidrop;
        #1;
        check({req, " R9 irq"}, {15'd0, irq}, {15'd0, |(m_evt & m_mask)});
        check({req, " R8 hunt"}, {15'd0, hunt_req}, {15'd0, m_hunt});
        reg_wr = 1'b0;
        reg_addr = 1'b0;
        #0.5;
        check({req, " R10 evt"}, reg_rdata, m_evt);
        reg_addr = 1'b1;
        #0.5;
        check({req, " R10 mask"}, reg_rdata, m_mask);
        @(negedge clk);
        quiet();
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog timeout");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #1;
        check("R1 irq", {15'd0, irq}, 16'd0);
        check("R1 hunt", {15'd0, hunt_req}, 16'd0);
        check("R1 rdata", reg_rdata, 16'd0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: each strobe alone lands at its bit
        rx_close = 1;   tick("R2 bit0");
        ctl_stored = 1; tick("R2 bit3");
        rx_glitch = 1;  tick("R2 bit12");
        addr_hit = 1;   tick("R2 bit9");
        check("R2 map", m_evt, 16'h1209);

        // R3: write 0 keeps, write 1 clears
        wr(0, 16'h0000); tick("R3 write0");
        wr(0, 16'h0008); tick("R3 clear bit3");
        check("R3 after clear", m_evt, 16'h1201);

        // R5: reserved bits ignore writes
        wr(1, 16'hFFFF); tick("R5 mask all");
        check("R5 mask", m_mask, 16'h1BEF);

        // R4: set and clear collide on bit0
        rx_close = 1; wr(0, 16'h0001); tick("R4 set wins");
        check("R4 bit0", {15'd0, m_evt[0]}, 16'd1);
        wr(0, 16'hFFFF); tick("R3 clear all");
        check("R9 irq off", {15'd0, irq}, 16'd0);

        // R6: break run gives one start
        brk_char = 1; tick("R6 first brk");
        wr(0, 16'h0020); tick("R6 clear");
        brk_char = 1; tick("R6 second brk");
        brk_char = 1; tick("R6 third brk");
        check("R6 no refire", {15'd0, m_evt[5]}, 16'd0);
        brk_char = 1; norm_char = 1; tick("R6 collide");
        brk_char = 1; tick("R6 still disarmed");
        check("R6 still low", {15'd0, m_evt[5]}, 16'd0);
        norm_char = 1; tick("R6 rearm");
        brk_char = 1; brk_end = 1; tick("R6 rearmed brk");
        check("R6 fired", {15'd0, m_evt[5]}, 16'd1);
        wr(0, 16'hFFFF); tick("R6 clr");

        // R7: transmit timing selection
        tx_cts_wait = 1; tx_last_fifo = 1; tick("R7 fifo ignored");
        check("R7 no tx", {15'd0, m_evt[1]}, 16'd0);
        tx_last_stop = 1; tick("R7 stop sets");
        wr(0, 16'h0002); tx_cts_wait = 0; tx_last_stop = 1; tick("R7 stop ignored");
        check("R7 no tx2", {15'd0, m_evt[1]}, 16'd0);
        tx_last_fifo = 1; tick("R7 fifo sets");

        // R8: hunt request
        multidrop = 0; rx_drop = 1; tick("R8 no hunt");
        multidrop = 1; rx_drop = 1; tick("R8 hunt");
        tick("R8 hunt drops");

        // random phase
        for (int i = 0; i < 400; i++) begin
            {rx_glitch, tx_glitch, addr_hit, idle_seen, stop_done, brk_end} = 6'($urandom);
            brk_char   = ($urandom % 3) == 0;
            norm_char  = ($urandom % 3) == 0;
            ctl_stored = $urandom;
            rx_drop    = $urandom;
            rx_close   = $urandom;
            tx_last_fifo = $urandom;
            tx_last_stop = $urandom;
            tx_cts_wait  = $urandom;
            multidrop    = $urandom;
            if (($urandom % 3) == 0) wr(1'($urandom), 16'($urandom));
            tick("R2 R4 R6 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule